// File: doc/BRIEF.md
# Timer Input Capture Unit

This block takes a snapshot of a free-running 16-bit timer whenever a chosen event appears on one external input pin. The pin is asynchronous to the system clock. It passes through a synchronizer, and edges are detected on the synchronized level. When the selected event occurs, the timer value present on the timer bus is stored in a high/low pair of capture registers, and an interrupt flag is raised. The flag stays raised until software clears it.

A 4-bit mode input selects the event: every falling edge, every rising edge, every 4th rising edge, or every 16th rising edge. All other codes, including the off code, disable capture. In the two divided modes an event prescaler counts rising edges. Only reset, the off code and non-capture codes clear this counter. Moving directly between the two divided ratios keeps the count, so the first capture after such a change can come early. Software that needs exact ratios turns the unit off before it changes the ratio. A new capture always overwrites the stored value, and no overrun indication exists.

Top module: `tmr_capture_top`

## Requirements
- R1: A capture copies the timer bus into the capture pair: bits 15:8 to `capHi` and bits 7:0 to `capLo`. A pin change made before clock edge k is captured at edge k+2, with the timer value present at that edge. The flag reads 1 after that edge and not before it.
- R2: With mode code 4'b0100, every falling edge of the pin captures. Rising edges have no effect.
- R3: With mode code 4'b0101, every rising edge of the pin captures. Falling edges have no effect.
- R4: Mode 4'b0110 captures on every 4th rising edge and mode 4'b0111 on every 16th. The prescaler returns to zero on each such capture, so the next capture needs a full count again.
- R5: Each capture sets `capFlag`. The flag stays at 1 until `flagClr` is high at a clock edge. A clear and a capture at the same edge leave the flag at 1.
- R6: A second capture before software reads replaces the stored value, and nothing signals the overrun.
- R7: Code 4'b0000 and every code not listed in R2 to R4 make no capture, and they clear the prescaler.
- R8: Reset clears the capture registers, the flag and the prescaler.
- R9: A direct switch between 4'b0110 and 4'b0111 keeps the prescaler count. A rising edge captures when the count already stands at or above ratio minus one, so a switch from /16 to /4 can capture early.
- R10: In modes 4'b0100 and 4'b0101 the prescaler holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| pinIn | input | 1 | External event pin, asynchronous |
| timerVal | input | 16 | Free-running timer value |
| modeSel | input | 4 | Capture mode code |
| flagClr | input | 1 | Software clear of the capture flag |
| capHi | output | 8 | Captured timer bits 15:8 |
| capLo | output | 8 | Captured timer bits 7:0 |
| capFlag | output | 1 | Capture interrupt flag |

## Verification
A software flag clear and a new capture can land on the same clock edge. The bench provokes this by counting the synchronizer latency from the pin change and raising `flagClr` for exactly the capture edge. The flag must still read 1 afterwards. The bench also pairs a prescaler ratio change with a partial count. The result is judged by whether the very next rising edge captures.

// File: rtl/capt_pkg.sv
package capt_pkg;
  localparam logic [3:0] MODE_OFF   = 4'b0000;
  localparam logic [3:0] MODE_FALL  = 4'b0100;
  localparam logic [3:0] MODE_RISE  = 4'b0101;
  localparam logic [3:0] MODE_DIVLO = 4'b0110;
  localparam logic [3:0] MODE_DIVHI = 4'b0111;

  typedef struct packed {
    logic loadCap;
    logic setFlag;
  } capStrobe_t;
endpackage

// File: rtl/capt_ctrl.sv
module capt_ctrl
  import capt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LO      = 4,
  parameter int DIV_HI      = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic [3:0] modeSel,
  output capStrobe_t stb
);
  localparam int PW = $clog2(DIV_HI);
  localparam logic [PW-1:0] TERM_LO = PW'(DIV_LO - 1);
  localparam logic [PW-1:0] TERM_HI = PW'(DIV_HI - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic syncOut, prevQ, riseEv, fallEv;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= pinIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
    end
  endgenerate

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncOut;

  assign riseEv = syncOut & ~prevQ;
  assign fallEv = ~syncOut & prevQ;

  logic [PW-1:0] prescQ, prescNext, term;
  logic isCap, divEn, hit, divHit;

  always_comb begin
    isCap = 1'b1;
    divEn = 1'b0;
    term  = TERM_LO;
    hit   = 1'b0;
    case (modeSel)
      MODE_FALL:  hit = fallEv;
      MODE_RISE:  hit = riseEv;
      MODE_DIVLO: begin divEn = 1'b1; term = TERM_LO; end
      MODE_DIVHI: begin divEn = 1'b1; term = TERM_HI; end
      default:    isCap = 1'b0;
    endcase
    divHit = divEn && riseEv && (prescQ >= term);
    if (divEn) hit = divHit;
    prescNext = prescQ;
    if (!isCap)                prescNext = '0;
    else if (divEn && riseEv)  prescNext = divHit ? '0 : prescQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prescQ <= '0;
    else       prescQ <= prescNext;

  assign stb.loadCap = hit;
  assign stb.setFlag = hit;

  assert_presc_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    !isCap |=> (prescQ == '0));
  assert_presc_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (divEn && stb.loadCap) |=> (prescQ == '0));
  assert_presc_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_FALL || modeSel == MODE_RISE) |=> $stable(prescQ));
endmodule

// File: rtl/capt_datapath.sv
module capt_datapath
  import capt_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  capStrobe_t         stb,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic               flagClr,
  output logic [TIMER_W-1:0] capVal,
  output logic               capFlag
);
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            capVal <= '0;
    else if (stb.loadCap) capVal <= timerVal;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            capFlag <= 1'b0;
    else if (stb.setFlag) capFlag <= 1'b1;
    else if (flagClr)     capFlag <= 1'b0;

  assert_cap_value_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCap |=> (capVal == $past(timerVal)));
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.setFlag |=> capFlag);
  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !flagClr) |=> capFlag);
  assert_cap_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadCap |=> $stable(capVal));
endmodule

// File: rtl/tmr_capture_top.sv
module tmr_capture_top
  import capt_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LO      = 4,
  parameter int DIV_HI      = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pinIn,
  input  logic [TIMER_W-1:0]     timerVal,
  input  logic [3:0]             modeSel,
  input  logic                   flagClr,
  output logic [TIMER_W/2-1:0]   capHi,
  output logic [TIMER_W/2-1:0]   capLo,
  output logic                   capFlag
);
  localparam int HALF = TIMER_W / 2;

  capStrobe_t stb;
  logic [TIMER_W-1:0] capVal;

  capt_ctrl #(.SYNC_STAGES(SYNC_STAGES), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) uCtrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .modeSel(modeSel), .stb(stb)
  );

  capt_datapath #(.TIMER_W(TIMER_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .timerVal(timerVal),
    .flagClr(flagClr), .capVal(capVal), .capFlag(capFlag)
  );

  assign capHi = capVal[TIMER_W-1:HALF];
  assign capLo = capVal[HALF-1:0];
endmodule

// File: tb/tb_tmr_capture_top.sv
`timescale 1ns/1ps
module tb_tmr_capture_top;
  logic clk = 1'b0, rstN = 1'b0, pinIn = 1'b0, flagClr = 1'b0;
  logic [15:0] timerVal = '0;
  logic [3:0]  modeSel = 4'b0000;
  logic [7:0]  capHi, capLo;
  logic        capFlag;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  tmr_capture_top dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .timerVal(timerVal),
    .modeSel(modeSel), .flagClr(flagClr), .capHi(capHi), .capLo(capLo),
    .capFlag(capFlag)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic setPin(input logic v);
    @(negedge clk); pinIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input logic [15:0] tv);
    @(negedge clk); timerVal = tv;
    setPin(1'b1);
    setPin(1'b0);
  endtask

  task automatic clearFlag();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  task automatic setMode(input logic [3:0] m);
    @(negedge clk); modeSel = m;
    @(negedge clk);
  endtask

  task automatic testReset_r8();
    chk("R8 reset capHi", capHi, 0);
    chk("R8 reset capLo", capLo, 0);
    chk("R8 reset flag", capFlag, 0);
  endtask

  task automatic testRise_r1_r3();
    setMode(4'b0101);
    @(negedge clk); timerVal = 16'hA5C3; pinIn = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 flag not yet set", capFlag, 0);
    @(negedge clk);
    chk("R1 flag after latency", capFlag, 1);
    chk("R1 capHi", capHi, 8'hA5);
    chk("R1 capLo", capLo, 8'hC3);
    clearFlag();
    chk("R5 flag cleared", capFlag, 0);
    @(negedge clk); timerVal = 16'h1111;
    setPin(1'b0);
    chk("R3 falling ignored flag", capFlag, 0);
    chk("R3 falling ignored value", {capHi, capLo}, 16'hA5C3);
  endtask

  task automatic testFall_r2();
    setMode(4'b0100);
    @(negedge clk); timerVal = 16'h1234;
    setPin(1'b1);
    chk("R2 rising ignored", capFlag, 0);
    setPin(1'b0);
    chk("R2 falling captured flag", capFlag, 1);
    chk("R2 falling captured value", {capHi, capLo}, 16'h1234);
    clearFlag();
  endtask

  task automatic testDiv_r4();
    setMode(4'b0000);
    setMode(4'b0110);
    for (int i = 0; i < 3; i++) pulse(16'h0100 + 16'(i));
    chk("R4 div4 no capture before 4th", capFlag, 0);
    pulse(16'h4444);
    chk("R4 div4 4th edge flag", capFlag, 1);
    chk("R4 div4 4th edge value", {capHi, capLo}, 16'h4444);
    clearFlag();
    for (int i = 0; i < 3; i++) pulse(16'h0200 + 16'(i));
    chk("R4 div4 wrap no early capture", capFlag, 0);
    pulse(16'h4545);
    chk("R4 div4 wrap capture", {capHi, capLo}, 16'h4545);
    clearFlag();
    setMode(4'b0000);
    setMode(4'b0111);
    for (int i = 0; i < 15; i++) pulse(16'h0300 + 16'(i));
    chk("R4 div16 no capture before 16th", capFlag, 0);
    pulse(16'h1616);
    chk("R4 div16 16th edge", {capHi, capLo}, 16'h1616);
    clearFlag();
  endtask

  task automatic testOverwrite_r6();
    setMode(4'b0101);
    pulse(16'hAAAA);
    pulse(16'hBBBB);
    chk("R6 overwrite value", {capHi, capLo}, 16'hBBBB);
    chk("R6 flag still single", capFlag, 1);
    clearFlag();
  endtask

  task automatic testClash_r5();
    setMode(4'b0101);
    clearFlag();
    @(negedge clk); timerVal = 16'hC1A5; pinIn = 1'b1;
    @(negedge clk); @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    chk("R5 capture beats clear", capFlag, 1);
    chk("R5 clash value", {capHi, capLo}, 16'hC1A5);
    repeat (3) @(negedge clk);
    chk("R5 flag holds", capFlag, 1);
    setPin(1'b0);
    clearFlag();
  endtask

  task automatic testOff_r7();
    setMode(4'b0000);
    pulse(16'hDEAD);
    chk("R7 off no capture", capFlag, 0);
    setMode(4'b1010);
    pulse(16'hBEEF);
    chk("R7 unused code no capture", capFlag, 0);
    chk("R7 value kept", {capHi, capLo}, 16'hC1A5);
    setMode(4'b0110);
    pulse(16'h0001); pulse(16'h0002);
    setMode(4'b0000);
    setMode(4'b0110);
    for (int i = 0; i < 3; i++) pulse(16'h0500 + 16'(i));
    chk("R7 prescaler cleared by off", capFlag, 0);
    pulse(16'h0707);
    chk("R7 capture after full count", {capHi, capLo}, 16'h0707);
    clearFlag();
  endtask

  task automatic testEarly_r9();
    setMode(4'b0000);
    setMode(4'b0111);
    for (int i = 0; i < 5; i++) pulse(16'h0600 + 16'(i));
    chk("R9 no capture at count 5", capFlag, 0);
    setMode(4'b0110);
    pulse(16'h0909);
    chk("R9 early capture flag", capFlag, 1);
    chk("R9 early capture value", {capHi, capLo}, 16'h0909);
    clearFlag();
  endtask

  task automatic testHold_r10();
    setMode(4'b0000);
    setMode(4'b0110);
    pulse(16'h0001); pulse(16'h0002);
    setMode(4'b0101);
    pulse(16'h1010);
    chk("R10 rising mode capture", {capHi, capLo}, 16'h1010);
    clearFlag();
    setMode(4'b0110);
    pulse(16'h0003);
    chk("R10 count held at 2", capFlag, 0);
    pulse(16'h1011);
    chk("R10 capture at held count", {capHi, capLo}, 16'h1011);
    clearFlag();
  endtask

  task automatic testMidReset_r8();
    setMode(4'b0000);
    setMode(4'b0110);
    pulse(16'h0001); pulse(16'h0002);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R8 mid reset value", {capHi, capLo}, 0);
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) pulse(16'h0800 + 16'(i));
    chk("R8 prescaler cleared by reset", capFlag, 0);
    pulse(16'h0808);
    chk("R8 capture after reset count", {capHi, capLo}, 16'h0808);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset_r8();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testRise_r1_r3();
    testFall_r2();
    testDiv_r4();
    testOverwrite_r6();
    testClash_r5();
    testOff_r7();
    testEarly_r9();
    testHold_r10();
    testMidReset_r8();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule